// File: doc/BRIEF.md
# Two-Tier Leveled Interrupt Arbiter

This block gathers a set of level-sensitive interrupt request lines and reduces them to a single pending request for a processor. Every source belongs to one of seven request levels, numbered 1 to 7, and holds one of nine priority slots within that level. The block reports the highest level that has an unmasked, active source. When the processor acknowledges a level, the block returns the vector number of the source that currently wins at that level.

A small group of low-numbered sources has a hardwired level and slot. Each of these sits in the top slot of its own level, so it can only be masked. Every other source takes its level, its slot and its mask bit from a per-source control word. Software writes and reads that word through a simple register port. Writing level 0 to a programmable source switches it off.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0, `ack_valid` is 0, and every source reads back with its mask bit set. Programmable sources read back with level 0 and slot 0.
- R2: A programmable source whose level field is 0 never contributes to `irq_level` and never wins an acknowledge.
- R3: `irq_level` equals the highest level that holds an active, unmasked, enabled source, and 0 when no such source exists. It appears one clock after the inputs that cause it.
- R4: Within one level, the active source with the larger slot value wins. Programmable slots run from 0 to 7.
- R5: Source i, for i below `NUM_LEVELS`, is fixed at level i+1 in slot 8, above every programmable slot. A write to such a source changes only its mask bit, and its readback shows level i+1 and slot 0.
- R6: The vector returned for winning source i is `VEC_BASE + i`.
- R7: When `ack_stb` is high, `ack_valid` is high exactly one clock later. `ack_vector` then carries the winner at `ack_level`, or `SPURIOUS_VEC` if that level has no active source (level 0 included).
- R8: Two active sources that share a level and a slot resolve to the lower source index.
- R9: A source whose mask bit is 1 is ignored, whatever its request line is.
- R10: The control word has this layout: bit 6 is the mask (1 = masked), bits 5:3 are the level and bits 2:0 are the slot. A read returns the word on `cfg_rdata` one clock after `cfg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_re | input | 1 | Control word read strobe |
| cfg_addr | input | IDX_W | Source index being accessed |
| cfg_wdata | input | 7 | Control word to write |
| cfg_rdata | output | 7 | Control word read back, registered |
| irq_req | input | NUM_SRC | Level-sensitive request lines |
| irq_level | output | 3 | Highest pending level, 0 when none, registered |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | VEC_W | Vector of the winner, or the spurious vector |

## Verification
The bench builds the block with 16 sources, which gives 7 fixed sources and 9 programmable ones, and keeps the other defaults. This size allows a full sweep of every level and slot value on every programmable source. It also allows all 256 request combinations of eight sources that share one level. A bench-side arithmetic model of level, slot and tie order scores pseudo-random mixed configurations, and it scores the acknowledge at every level for each of them.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W  = 3;
  localparam int SLOT_W = 3;
  localparam int PRIO_W = SLOT_W + 1;
  localparam int CFG_W  = 1 + LVL_W + SLOT_W;
  // fixed sources sit one step above the highest programmable slot
  localparam logic [PRIO_W-1:0] FIXED_PRIO = PRIO_W'(1 << SLOT_W);
endpackage

// File: rtl/intc_cfg_bank.sv
module intc_cfg_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic                             re,
  input  logic [IDX_W-1:0]                 addr,
  input  logic [CFG_W-1:0]                 wdata,
  output logic [CFG_W-1:0]                 rdata,
  output logic [NUM_SRC-1:0]               src_mask,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   src_prio
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic sel;
    assign sel = we && (addr == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)      src_mask[i] <= 1'b1;
      else if (sel) src_mask[i] <= wdata[CFG_W-1];
    end

    if (i < NUM_FIXED) begin : g_fixed
      assign src_lvl[i]  = LVL_W'(i + 1);
      assign src_prio[i] = FIXED_PRIO;
    end else begin : g_prog
      logic [LVL_W-1:0]  lvl_q;
      logic [SLOT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lvl_q  <= '0;
          slot_q <= '0;
        end else if (sel) begin
          lvl_q  <= wdata[SLOT_W +: LVL_W];
          slot_q <= wdata[SLOT_W-1:0];
        end
      end
      assign src_lvl[i]  = lvl_q;
      assign src_prio[i] = {1'b0, slot_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (int'(addr) < NUM_SRC)
        rdata <= {src_mask[addr], src_lvl[addr], src_prio[addr][SLOT_W-1:0]};
      else
        rdata <= '0;
    end
  end

endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
  import intc_pkg::*;
#(
  parameter int               NUM_SRC = 63,
  parameter int               IDX_W   = $clog2(NUM_SRC),
  parameter logic [LVL_W-1:0] LEVEL   = 3'd1
) (
  input  logic [NUM_SRC-1:0]               act,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]   src_prio,
  output logic                             hit,
  output logic [IDX_W-1:0]                 win_idx
);

  logic [PRIO_W-1:0] best;

  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    hit     = 1'b0;
    best    = '0;
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && (src_lvl[i] == LEVEL) && (!hit || (src_prio[i] > best))) begin
        hit     = 1'b1;
        best    = src_prio[i];
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC      = 63,
  parameter int NUM_LEVELS   = 7,
  parameter int VEC_W        = 8,
  parameter int VEC_BASE     = 64,
  parameter int SPURIOUS_VEC = 24,
  parameter int IDX_W        = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [6:0]         cfg_wdata,
  output logic [6:0]         cfg_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [2:0]         irq_level,
  input  logic               ack_stb,
  input  logic [2:0]         ack_level,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_vector
);

  localparam int NUM_FIXED = NUM_LEVELS;

  logic [NUM_SRC-1:0]               src_mask;
  logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl;
  logic [NUM_SRC-1:0][PRIO_W-1:0]   src_prio;
  logic [NUM_SRC-1:0]               act;
  logic [NUM_LEVELS:1]              lvl_hit;
  logic [IDX_W-1:0]                 lvl_win [NUM_LEVELS:1];
  logic [LVL_W-1:0]                 top_lvl;
  logic [VEC_W-1:0]                 ack_vec_d;

  intc_cfg_bank #(
    .NUM_SRC   (NUM_SRC),
    .NUM_FIXED (NUM_FIXED),
    .IDX_W     (IDX_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .re       (cfg_re),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .src_mask (src_mask),
    .src_lvl  (src_lvl),
    .src_prio (src_prio)
  );

  assign act = irq_req & ~src_mask;

  for (genvar L = 1; L <= NUM_LEVELS; L++) begin : g_lvl
    intc_level_arb #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W),
      .LEVEL   (LVL_W'(L))
    ) u_arb (
      .act      (act),
      .src_lvl  (src_lvl),
      .src_prio (src_prio),
      .hit      (lvl_hit[L]),
      .win_idx  (lvl_win[L])
    );
  end

  always_comb begin
    top_lvl = '0;
    for (int L = 1; L <= NUM_LEVELS; L++)
      if (lvl_hit[L]) top_lvl = LVL_W'(L);
  end

  always_comb begin
    ack_vec_d = VEC_W'(SPURIOUS_VEC);
    for (int L = 1; L <= NUM_LEVELS; L++)
      if ((ack_level == LVL_W'(L)) && lvl_hit[L])
        ack_vec_d = VEC_W'(VEC_BASE) + VEC_W'(lvl_win[L]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level  <= '0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      irq_level <= top_lvl;
      ack_valid <= ack_stb;
      if (ack_stb) ack_vector <= ack_vec_d;
    end
  end

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC      = 63,
  parameter int NUM_LEVELS   = 7,
  parameter int VEC_W        = 8,
  parameter int VEC_BASE     = 64,
  parameter int SPURIOUS_VEC = 24
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] src_mask,
  input logic [2:0]         irq_level,
  input logic               ack_stb,
  input logic [2:0]         ack_level,
  input logic               ack_valid,
  input logic [VEC_W-1:0]   ack_vector
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_level == 3'd0 && !ack_valid));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ((irq_req & ~src_mask) == '0) |=> (irq_level == 3'd0));

  p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
    irq_level <= 3'(NUM_LEVELS));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ack_stb |=> ack_valid);

  p_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    !ack_stb |=> !ack_valid);

  p_level0_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && ack_level == 3'd0) |=> (ack_vector == VEC_W'(SPURIOUS_VEC)));

  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_vector != VEC_W'(SPURIOUS_VEC)) |->
      (ack_vector >= VEC_W'(VEC_BASE) && ack_vector < VEC_W'(VEC_BASE + NUM_SRC)));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .NUM_SRC      (NUM_SRC),
  .NUM_LEVELS   (NUM_LEVELS),
  .VEC_W        (VEC_W),
  .VEC_BASE     (VEC_BASE),
  .SPURIOUS_VEC (SPURIOUS_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .src_mask   (src_mask),
  .irq_level  (irq_level),
  .ack_stb    (ack_stb),
  .ack_level  (ack_level),
  .ack_valid  (ack_valid),
  .ack_vector (ack_vector)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
  localparam int NS    = 16;
  localparam int IW    = 4;
  localparam int NLV   = 7;
  localparam int VBASE = 64;
  localparam int SPUR  = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_re = 1'b0;
  logic [IW-1:0] cfg_addr = '0;
  logic [6:0]    cfg_wdata = '0;
  logic [6:0]    cfg_rdata;
  logic [NS-1:0] irq_req = '0;
  logic [2:0]    irq_level;
  logic          ack_stb = 1'b0;
  logic [2:0]    ack_level = '0;
  logic          ack_valid;
  logic [7:0]    ack_vector;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_lvl [NS];
  int m_prio[NS];
  bit m_mask[NS];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  irq_level_ctrl #(
    .NUM_SRC(NS), .NUM_LEVELS(NLV), .VEC_W(8),
    .VEC_BASE(VBASE), .SPURIOUS_VEC(SPUR), .IDX_W(IW)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .ack_stb(ack_stb),
    .ack_level(ack_level), .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_win(input logic [NS-1:0] req, input int lvl);
    int w = -1, best = -1;
    for (int i = 0; i < NS; i++)
      if (req[i] && !m_mask[i] && m_lvl[i] == lvl && lvl != 0 && m_prio[i] > best) begin
        best = m_prio[i];
        w = i;
      end
    return w;
  endfunction

  function automatic int model_top(input logic [NS-1:0] req);
    for (int L = NLV; L >= 1; L--)
      if (model_win(req, L) >= 0) return L;
    return 0;
  endfunction

  function automatic int model_vec(input logic [NS-1:0] req, input int lvl);
    int w = model_win(req, lvl);
    return (w >= 0) ? VBASE + w : SPUR;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic wcfg(input int a, input bit msk, input int l, input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = IW'(a);
    cfg_wdata = {msk, 3'(l), 3'(s)};
    @(negedge clk);
    cfg_we = 1'b0;
    m_mask[a] = msk;
    if (a >= NLV) begin
      m_lvl[a] = l;
      m_prio[a] = s;
    end
  endtask

  task automatic rcfg(input int a, output int v);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = IW'(a);
    @(negedge clk);
    cfg_re = 1'b0;
    v = int'(cfg_rdata);
  endtask

  task automatic set_req(input logic [NS-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input int l, output int vec, output bit vld);
    @(negedge clk);
    ack_stb = 1'b1; ack_level = 3'(l);
    @(negedge clk);
    ack_stb = 1'b0;
    vec = int'(ack_vector);
    vld = ack_valid;
  endtask

  task automatic check_all(input string tag);
    int v; bit vd;
    chk({tag, " R3 level"}, int'(irq_level), model_top(irq_req));
    for (int L = 1; L <= NLV; L++) begin
      do_ack(L, v, vd);
      chk({tag, " R7 valid"}, int'(vd), 1);
      chk({tag, " R4/R8 vector"}, v, model_vec(irq_req, L));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v; bit vd;
    for (int i = 0; i < NS; i++) begin
      m_mask[i] = 1'b1;
      m_lvl[i]  = (i < NLV) ? i + 1 : 0;
      m_prio[i] = (i < NLV) ? 8 : 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_level", int'(irq_level), 0);
    chk("R1 ack_valid", int'(ack_valid), 0);
    for (int i = 0; i < NS; i++) begin
      rcfg(i, v);
      chk("R1/R5 readback", v, 64 + ((i < NLV) ? (i + 1) * 8 : 0));
    end

    // R9: all lines requesting but all masked
    set_req('1);
    chk("R9 all masked", int'(irq_level), 0);
    do_ack(1, v, vd);
    chk("R9 masked ack", v, SPUR);
    set_req('0);

    // R10: field layout readback
    wcfg(10, 1'b1, 5, 3);
    rcfg(10, v);
    chk("R10 layout", v, 64 + 5 * 8 + 3);
    wcfg(10, 1'b0, 6, 1);
    rcfg(10, v);
    chk("R10 layout", v, 6 * 8 + 1);
    wcfg(10, 1'b1, 0, 0);

    // R2 R3 R6 R7: sweep every level and slot on each programmable source
    for (int s = NLV; s < NS; s++) begin
      for (int l = 0; l < 8; l++) begin
        for (int sl = 0; sl < 8; sl++) begin
          wcfg(s, 1'b0, l, sl);
          set_req(NS'(1) << s);
          chk("R2/R3 single level", int'(irq_level), l);
          do_ack(l, v, vd);
          chk("R6/R7 single vector", v, (l == 0) ? SPUR : VBASE + s);
        end
      end
      wcfg(s, 1'b1, 0, 0);
      set_req('0);
      chk("R3 cleared", int'(irq_level), 0);
    end

    // R7: valid is a one-cycle pulse; an idle level yields the spurious vector
    wcfg(8, 1'b0, 2, 0);
    set_req(NS'(1) << 8);
    do_ack(6, v, vd);
    chk("R7 idle level spurious", v, SPUR);
    chk("R7 valid high", int'(vd), 1);
    @(negedge clk);
    chk("R7 valid drops", int'(ack_valid), 0);
    wcfg(8, 1'b1, 0, 0);
    set_req('0);

    // R5: fixed sources ignore level/slot writes
    for (int i = 0; i < NLV; i++) begin
      wcfg(i, 1'b0, 7, 7);
      rcfg(i, v);
      chk("R5 fixed readback", v, (i + 1) * 8);
      set_req(NS'(1) << i);
      chk("R5 fixed level", int'(irq_level), i + 1);
      do_ack(i + 1, v, vd);
      chk("R5/R6 fixed vector", v, VBASE + i);
    end
    // R5: fixed slot beats programmable slot 7 on the same level
    wcfg(13, 1'b0, 4, 7);
    set_req((NS'(1) << 13) | (NS'(1) << 3));
    do_ack(4, v, vd);
    chk("R5 fixed outranks slot 7", v, VBASE + 3);
    for (int i = 0; i < NLV; i++) wcfg(i, 1'b1, 0, 0);
    wcfg(13, 1'b1, 0, 0);

    // R4: every request combination of eight sources sharing level 3
    for (int s = NLV; s < NLV + 8; s++) wcfg(s, 1'b0, 3, s - NLV);
    for (int p = 0; p < 256; p++) begin
      set_req(NS'(p) << NLV);
      chk("R4 shared level", int'(irq_level), (p == 0) ? 0 : 3);
      do_ack(3, v, vd);
      chk("R4 slot order", v, model_vec(irq_req, 3));
    end
    for (int s = NLV; s < NLV + 8; s++) wcfg(s, 1'b1, 0, 0);

    // R8: identical level and slot, the lower index wins
    wcfg(9, 1'b0, 5, 4);
    wcfg(12, 1'b0, 5, 4);
    set_req((NS'(1) << 9) | (NS'(1) << 12));
    do_ack(5, v, vd);
    chk("R8 tie lower index", v, VBASE + 9);
    set_req(NS'(1) << 12);
    do_ack(5, v, vd);
    chk("R8 tie other alone", v, VBASE + 12);

    // R9: masking an active source removes it
    wcfg(12, 1'b1, 5, 4);
    set_req(NS'(1) << 12);
    chk("R9 masked live source", int'(irq_level), 0);
    wcfg(9, 1'b1, 0, 0);
    set_req('0);

    // mixed pseudo-random configurations
    for (int round = 0; round < 4; round++) begin
      for (int s = 0; s < NS; s++) begin
        step_lfsr();
        wcfg(s, lfsr[0] & lfsr[5], int'(lfsr[3:1]), int'(lfsr[8:6]));
      end
      for (int p = 0; p < 40; p++) begin
        step_lfsr();
        set_req(lfsr);
        check_all("mixed");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule